// File: doc/BRIEF.md
# Half-Full Flagged FIFO with Read Rewind

This block is a single-clock first-in/first-out buffer for 9-bit words, so a parity or control bit can travel beside each data byte. The words sit in a RAM that two ring pointers address; the write pointer and the read pointer each carry one bit more than the address, so a completely full buffer and an empty one can be told apart. A write strobe stores `din` and a read strobe fetches the oldest word into a registered output. The block drives three active-low status flags: empty, full and half-full.

An active-low rewind input moves the read pointer back to location zero and leaves the write pointer where it is. Everything written since reset can then be read again from the first word. This only has a defined result while fewer than `DEPTH` words have been written since reset. The depth is a power-of-two parameter with a default of 256 words. A second parameter chooses whether the flags come from flops loaded from the next pointer values or from decoding the current pointers. The flags are visible in the same cycle with either choice.

Top module: `hfq_fifo`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, both pointers are at location zero. In that state `empty_n`=0, `full_n`=1, `half_n`=1, `dout_vld`=0 and `dout`=0.
- R2: Words are 9 bits wide and come out in the order they were written. On the clock edge that accepts a read, `dout` takes the oldest stored word and `dout_vld` goes high for that one cycle.
- R3: A write presented while `full_n` is low is ignored. The write pointer does not advance, and no stored word is overwritten.
- R4: A read presented while `empty_n` is low is ignored. The read pointer does not advance and `dout_vld` stays low.
- R5: `full_n` is low exactly when the buffer holds `DEPTH` words. After reset, `DEPTH` writes with no read bring it low.
- R6: `empty_n` is low exactly when the read pointer equals the write pointer. `empty_n` and `full_n` are never low together.
- R7: `half_n` goes low on the write that makes the stored count exceed `DEPTH/2`. It returns high on the read that brings the count to `DEPTH/2` or less.
- R8: A clock edge with `rewind_n` low sets the read pointer to location zero and leaves the write pointer unchanged. The flags then follow the new pointer difference, and the following reads replay the words from the first one written after reset.
- R9: In a cycle with `rewind_n` low, `wr_en` and `rd_en` are ignored.
- R10: A write and a read in the same cycle are both accepted when each one's flag permits it. On an empty buffer only the write is taken. On a full buffer only the read is taken, and after that read one new write is accepted.
- R11: `dout` holds its value in every cycle that does not accept a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one word per cycle while high |
| din | input | WIDTH (9) | Word to store |
| rd_en | input | 1 | Read strobe, one word per cycle while high |
| rewind_n | input | 1 | Rewind read pointer to location zero, active low |
| dout | output | WIDTH (9) | Registered read word |
| dout_vld | output | 1 | High for the cycle after an accepted read |
| empty_n | output | 1 | Empty flag, active low |
| full_n | output | 1 | Full flag, active low |
| half_n | output | 1 | More than half full, active low |

## Verification
Every result of an accepted or rejected strobe, including the read word, `dout_vld` and all three flags, is due on the first rising edge after the strobe is presented. There is no further latency. The bench drives its stimulus on the falling edge. It updates a reference count and a word store at the next rising edge and compares every output on the falling edge after that, so each comparison lands one edge after its cause. Rewinds follow the same rule: the replayed word appears on the edge of the first read after the rewind cycle.

// File: rtl/hfq_pkg.sv
package hfq_pkg;

   localparam int unsigned HFQ_WORD_W = 9;
   localparam int unsigned HFQ_DEPTH  = 256;

   function automatic bit hfq_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/hfq_ptr.sv
module hfq_ptr #(
   parameter int unsigned AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [AW:0]   ptr,
   output logic [AW:0]   ptr_nxt
);

   always_comb begin
      if (clr)
         ptr_nxt = '0;
      else if (inc)
         ptr_nxt = ptr + 1'b1;
      else
         ptr_nxt = ptr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else
         ptr <= ptr_nxt;
   end

endmodule

// File: rtl/hfq_ram.sv
module hfq_ram #(
   parameter int unsigned WIDTH = 9,
   parameter int unsigned DEPTH = 256,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             re,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (re)
         rdata <= mem[raddr];
   end

endmodule

// File: rtl/hfq_flags.sv
module hfq_flags #(
   parameter int unsigned DEPTH     = 256,
   parameter bit          REG_FLAGS = 1'b1,
   localparam int unsigned AW       = $clog2(DEPTH)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [AW:0] wsel,
   input  logic [AW:0] rsel,
   output logic        empty_n,
   output logic        full_n,
   output logic        half_n
);

   localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);
   localparam logic [AW:0] CNT_HALF = CNT_FULL >> 1;

   logic [AW:0] fill;
   logic        e_n_d, f_n_d, h_n_d;

   // fill level from the selected pointer pair
   assign fill  = wsel - rsel;
   assign e_n_d = (fill != '0);
   assign f_n_d = (fill != CNT_FULL);
   assign h_n_d = (fill <= CNT_HALF);

   generate
      if (REG_FLAGS) begin : g_reg
         // pointers given here are next-state values
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               empty_n <= 1'b0;
               full_n  <= 1'b1;
               half_n  <= 1'b1;
            end else begin
               empty_n <= e_n_d;
               full_n  <= f_n_d;
               half_n  <= h_n_d;
            end
         end
      end else begin : g_comb
         // pointers given here are the current registered values
         assign empty_n = e_n_d;
         assign full_n  = f_n_d;
         assign half_n  = h_n_d;
      end
   endgenerate

   // R7: half-full implies at least one word is stored
   p_half_not_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !half_n |-> empty_n);

   // R6: empty and full exclusive
   p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      empty_n || full_n);

endmodule

// File: rtl/hfq_fifo.sv
module hfq_fifo #(
   parameter int unsigned WIDTH     = hfq_pkg::HFQ_WORD_W,
   parameter int unsigned DEPTH     = hfq_pkg::HFQ_DEPTH,
   parameter bit          REG_FLAGS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] din,
   input  logic             rd_en,
   input  logic             rewind_n,
   output logic [WIDTH-1:0] dout,
   output logic             dout_vld,
   output logic             empty_n,
   output logic             full_n,
   output logic             half_n
);

   localparam int unsigned AW = $clog2(DEPTH);

   generate
      if (!hfq_pkg::hfq_is_pow2(DEPTH) || DEPTH < 4) begin : g_bad_depth
         $error("hfq_fifo: DEPTH must be a power of two, at least 4");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("hfq_fifo: WIDTH must be at least 1");
      end
   endgenerate

   logic        rew;
   logic        wr_ok, rd_ok;
   logic [AW:0] wptr, wptr_nxt, rptr, rptr_nxt;
   logic [AW:0] wsel, rsel;

   assign rew   = !rewind_n;
   assign wr_ok = wr_en && full_n  && !rew;
   assign rd_ok = rd_en && empty_n && !rew;

   hfq_ptr #(.AW(AW)) u_wptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (1'b0),
      .inc     (wr_ok),
      .ptr     (wptr),
      .ptr_nxt (wptr_nxt)
   );

   hfq_ptr #(.AW(AW)) u_rptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (rew),
      .inc     (rd_ok),
      .ptr     (rptr),
      .ptr_nxt (rptr_nxt)
   );

   hfq_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_ok),
      .waddr (wptr[AW-1:0]),
      .wdata (din),
      .re    (rd_ok),
      .raddr (rptr[AW-1:0]),
      .rdata (dout)
   );

   assign wsel = REG_FLAGS ? wptr_nxt : wptr;
   assign rsel = REG_FLAGS ? rptr_nxt : rptr;

   hfq_flags #(.DEPTH(DEPTH), .REG_FLAGS(REG_FLAGS)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .wsel    (wsel),
      .rsel    (rsel),
      .empty_n (empty_n),
      .full_n  (full_n),
      .half_n  (half_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dout_vld <= 1'b0;
      else
         dout_vld <= rd_ok;
   end

   // R3: write while full leaves the write pointer alone
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_n && wr_en) |=> $stable(wptr));

   // R4: read while empty produces no valid word
   p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty_n && rd_en) |=> !dout_vld);

   // R8: rewind zeroes the read pointer and keeps the write pointer
   p_rewind_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rewind_n |=> ((rptr == '0) && $stable(wptr)));

   // R9: strobes during rewind produce no read
   p_rewind_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rewind_n |=> !dout_vld);

   // R11: output word held when no read is taken
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && empty_n && rewind_n) |=> $stable(dout));

endmodule

// File: tb/sim_hfq_fifo.sv
`timescale 1ns/1ps
module sim_hfq_fifo;

   localparam int DEP = 16;
   localparam int W   = 9;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0, rd_en = 1'b0, rewind_n = 1'b1;
   logic [W-1:0] din = '0;
   logic [W-1:0] dout;
   logic         dout_vld, empty_n, full_n, half_n;

   always #2 clk = ~clk;

   hfq_fifo #(.WIDTH(W), .DEPTH(DEP)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .din(din), .rd_en(rd_en),
      .rewind_n(rewind_n), .dout(dout), .dout_vld(dout_vld),
      .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
   );

   int total = 0, bad = 0;
   bit finished = 1'b0;

   // reference state
   logic [W-1:0] mdata [DEP];
   int           wcnt, rcnt;
   logic [W-1:0] exp_dout;
   logic         exp_vld;

   function automatic int fill_lvl();
      return wcnt - rcnt;
   endfunction

   task automatic chk(input string req, input string what, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic check_all(input string tdata, input string tflag);
      chk(tdata, "dout_vld", int'(dout_vld), int'(exp_vld));
      chk(tdata, "dout", int'(dout), int'(exp_dout));
      chk(tflag == "" ? "R6" : tflag, "empty_n", int'(empty_n), int'(fill_lvl() != 0));
      chk(tflag == "" ? "R5" : tflag, "full_n", int'(full_n), int'(fill_lvl() != DEP));
      chk(tflag == "" ? "R7" : tflag, "half_n", int'(half_n), int'(fill_lvl() <= DEP/2));
   endtask

   task automatic do_reset();
      rst_n = 1'b0; wr_en = 0; rd_en = 0; rewind_n = 1;
      @(posedge clk);
      @(negedge clk);
      wcnt = 0; rcnt = 0; exp_dout = '0; exp_vld = 1'b0;
      check_all("R1", "R1");
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check_all("R1", "R1");
   endtask

   // one cycle: drive at falling edge, model at rising edge, check at next falling edge
   task automatic cyc(input bit w, input bit r, input bit rw, input logic [W-1:0] d);
      bit    wok, rok;
      string td, tf;
      wr_en = w; rd_en = r; rewind_n = !rw; din = d;
      td = ""; tf = "";
      if (rw && (w || r)) begin td = "R9"; tf = "R9"; end
      else if (rw) begin td = "R8"; tf = "R8"; end
      else if (w && r) tf = "R10";
      else if (w && fill_lvl() == DEP) tf = "R3";
      else if (r && fill_lvl() == 0) tf = "R4";
      wok = w && fill_lvl() < DEP && !rw;
      rok = r && fill_lvl() > 0 && !rw;
      @(posedge clk);
      if (rok) begin
         exp_dout = mdata[rcnt % DEP];
         rcnt++;
      end
      exp_vld = rok;
      if (wok) begin
         mdata[wcnt % DEP] = d;
         wcnt++;
      end
      if (rw) rcnt = 0;
      @(negedge clk);
      if (td == "") td = rok ? (w ? "R10" : "R2") : (r && !rw ? "R4" : "R11");
      check_all(td, tf);
      wr_en = 0; rd_en = 0; rewind_n = 1;
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      do_reset();

      // R5/R7: fill to DEP from reset
      for (int i = 0; i < DEP; i++) cyc(1, 0, 0, W'(9'h100 + i * 7));
      chk("R5", "full after DEP writes", int'(full_n), 0);
      // R3: writes on full are dropped
      cyc(1, 0, 0, 9'h0AA);
      cyc(1, 0, 0, 9'h155);
      // R10: read and write on full, only read taken, then one write fits
      cyc(1, 1, 0, 9'h1EE);
      cyc(1, 0, 0, 9'h133);
      cyc(1, 0, 0, 9'h144);
      // R2/R7: drain in order
      for (int i = 0; i < DEP; i++) cyc(0, 1, 0, '0);
      // R4: reads on empty ignored, R11 dout held
      cyc(0, 1, 0, '0);
      cyc(0, 1, 0, '0);
      cyc(0, 0, 0, '0);
      // R10: read and write on empty, write only
      cyc(1, 1, 0, 9'h1C3);
      cyc(1, 1, 0, 9'h03C);
      cyc(0, 1, 0, '0);

      // R8: rewind replays from the first word after reset
      do_reset();
      for (int i = 0; i < 10; i++) cyc(1, 0, 0, W'(9'h050 + i));
      for (int i = 0; i < 4; i++) cyc(0, 1, 0, '0);
      cyc(0, 0, 1, '0);
      for (int i = 0; i < 3; i++) cyc(0, 1, 0, '0);
      // R9: strobes during rewind ignored
      cyc(1, 1, 1, 9'h1FF);
      cyc(0, 1, 0, '0);

      // constrained random with bias phases
      do_reset();
      for (int n = 0; n < 4000; n++) begin
         int  bias;
         bit  w, r, rw;
         bias = ((n / 150) % 2 == 0) ? 75 : 30;
         w  = ($urandom % 100) < bias;
         r  = ($urandom % 100) < (100 - bias);
         rw = (wcnt < DEP) && (($urandom % 100) < 3);
         if (rw && ($urandom % 4 != 0)) begin w = 0; r = 0; end
         cyc(w, r, rw, W'($urandom));
         if (wcnt >= 4 * DEP && ($urandom % 40 == 0)) do_reset();
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule